// File: doc/BRIEF.md
# Half-Duplex Line Transmitter with Turnaround Guard

This block drives bytes onto a shared serial data line that both ends use in turn, one bit per line clock. When its owner asks it to take the line (`tx_mode` goes high while the line is released), it drives the line high for a fixed turnaround of two idle bits plus a selectable guard time. Only then can the first start bit go out. After that it sends each byte it accepts over a valid/ready handshake as a twelve-bit frame. Consecutive frames in transmit mode follow each other with no gap and no further guard time.

Whenever the block drives a one, it compares the line value it reads back with the value it drives. A low reading means the other end is driving the line, so the block stops the frame, releases the line and raises a sticky collision flag. A continuous low (a break) from the other end during transmission is treated the same way. It is caught no later than the stop bits, because the stop bits are always high. The flag stays set until the owner drops `tx_mode` and then raises it again, which starts a new turnaround.

Top module: `hdx_tx`

## Requirements
- R1: While reset is asserted, and afterwards while `tx_mode` is low, `drv_en`, `byte_ready` and `collision` are all 0.
- R2: In the clock after the one where `tx_mode` is first seen high with the line released, the block starts driving high bits. It drives exactly 2 + extra high bits before the start bit. If a byte is already offered, its start bit comes in the very next bit. `byte_ready` stays low until the last of those bits.
- R3: The extra guard time comes from `guard_sel`, which is read only in the turnaround clock. Codes 0 and 1 give 128 extra bits. A code c from 2 to 7 gives 256 >> c extra bits (64, 32, 16, 8, 4, 2).
- R4: A frame takes 12 consecutive clocks. The order is a start bit of 0, then the 8 data bits least significant first, then an even parity bit equal to the XOR of the data bits, then two stop bits of 1.
- R5: `byte_ready` is high only while `tx_mode` is high and no collision is being detected. Within that, it is high in three cases: the line is idle in transmit mode, the last guard bit is being driven, or the second stop bit is being driven. A byte taken during the second stop bit starts its start bit in the next clock, with no idle bit and no guard time. With no byte offered, the line stays driven high.
- R6: If `tx_mode` goes low during guard time or transmit idle, the line is released in the next clock. If it goes low during a frame, the frame completes and the line is released in the clock after the second stop bit.
- R7: In any clock where the block drives a 1 but reads 0 on `line_in`, it releases the line (`drv_en` = 0) in the next clock, sets `collision` and drops the rest of the frame. A low reading while driving a 0 has no effect.
- R8: The other end can hold the line low as a break during a frame. This raises `collision` no later than the first stop bit.
- R9: `collision` stays at 1, with the line released, until `tx_mode` has been low for at least one clock. It is cleared in the clock after the next turnaround, when the guard bits begin.
- R10: `byte_valid` has no effect while `byte_ready` is low. A byte offered during a frame, and withdrawn before the second stop bit, is never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_mode | input | 1 | Request to own the line (1) or release it (0) |
| guard_sel | input | 3 | Extra guard time code, read at turnaround |
| byte_data | input | 8 | Byte to transmit |
| byte_valid | input | 1 | `byte_data` is offered |
| byte_ready | output | 1 | Byte is taken in this clock if offered |
| line_in | input | 1 | Value read back from the shared line |
| drv_en | output | 1 | Line driver enable |
| drv_data | output | 1 | Value driven when enabled |
| collision | output | 1 | Sticky collision flag |

## Verification
The hardest state to reach from the ports is a collision on a specific bit: the other end must pull the line low exactly while the block drives a one, and not while it drives a zero. The bench models the shared line as wired to the block's own output, with an override that forces it low. It raises the override from a chosen bit index inside a frame, and the byte is chosen so that index holds a zero and the next bit a one. A second scenario holds the line low across an all-zero frame to reproduce a break that only the stop bits can catch. Random turnarounds change `guard_sel` after the turnaround clock to show that the guard length was taken once.

// File: rtl/hdx_pkg.sv
package hdx_pkg;

  localparam int GUARD_LOG = 7;
  localparam int MAND_IDLE = 2;
  localparam int SEL_W     = 3;
  localparam int GCNT_W    = $clog2(MAND_IDLE + (1 << GUARD_LOG));

  typedef enum logic [2:0] {
    ST_RX    = 3'd0,
    ST_GUARD = 3'd1,
    ST_IDLE  = 3'd2,
    ST_FRAME = 3'd3,
    ST_LOCK  = 3'd4
  } tx_state_e;

  // Extra idle bits selected by the code: 0 and 1 give the maximum,
  // each higher code halves it.
  function automatic int unsigned guard_extra(input logic [SEL_W-1:0] sel);
    int unsigned ext;
    if (sel < SEL_W'(2)) ext = 32'd1 << GUARD_LOG;
    else                 ext = 32'd1 << (GUARD_LOG + 1 - int'(sel));
    return ext;
  endfunction

  // Value loaded into the guard down-counter: total idle bits minus one.
  function automatic logic [GCNT_W-1:0] guard_load(input logic [SEL_W-1:0] sel);
    int unsigned total;
    total = MAND_IDLE + guard_extra(sel) - 1;
    return total[GCNT_W-1:0];
  endfunction

endpackage

// File: rtl/hdx_guard_timer.sv
module hdx_guard_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (load)                       cnt_q <= load_val;
    else if (run && (cnt_q != '0))       cnt_q <= cnt_q - CNT_W'(1);
  end

  assign done = (cnt_q == '0);

  // A fresh turnaround always leaves at least two idle bits to go.
  assert_guard_min_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (load_val != '0)) |=> !done);

  assert_guard_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !run) |=> $stable(cnt_q));

endmodule

// File: rtl/hdx_frame_shift.sv
module hdx_frame_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              advance,
  output logic              bit_out,
  output logic              last_bit
);

  localparam int FRAME_W = DATA_W + 4;
  localparam int IDX_W   = $clog2(FRAME_W);

  logic [FRAME_W-1:0] sr_q;
  logic [IDX_W-1:0]   idx_q;

  function automatic logic [FRAME_W-1:0] build_frame(input logic [DATA_W-1:0] d);
    return {2'b11, ^d, d, 1'b0};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '1;
      idx_q <= '0;
    end else if (load) begin
      sr_q  <= build_frame(load_data);
      idx_q <= '0;
    end else if (advance) begin
      sr_q  <= {1'b1, sr_q[FRAME_W-1:1]};
      if (!last_bit) idx_q <= idx_q + IDX_W'(1);
    end
  end

  assign bit_out  = sr_q[0];
  assign last_bit = (idx_q == IDX_W'(FRAME_W - 1));

  assert_start_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !bit_out);

  assert_stop_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && (idx_q >= IDX_W'(FRAME_W - 2))) |-> bit_out);

endmodule

// File: rtl/hdx_tx.sv
module hdx_tx
  import hdx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_mode,
  input  logic [SEL_W-1:0]  guard_sel,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              byte_valid,
  output logic              byte_ready,
  input  logic              line_in,
  output logic              drv_en,
  output logic              drv_data,
  output logic              collision
);

  tx_state_e         st_q, st_d;
  logic              turn_evt, coll_evt, accept;
  logic              g_done, g_run;
  logic [GCNT_W-1:0] g_val;
  logic              f_bit, f_last, f_adv;
  logic              coll_q;

  // Named internal events
  assign turn_evt = (st_q == ST_RX) && tx_mode;
  assign g_val    = guard_load(guard_sel);
  assign g_run    = (st_q == ST_GUARD);
  assign f_adv    = (st_q == ST_FRAME);

  assign drv_en   = (st_q == ST_GUARD) || (st_q == ST_IDLE) || (st_q == ST_FRAME);
  assign drv_data = (st_q == ST_FRAME) ? f_bit : 1'b1;
  assign coll_evt = drv_en && drv_data && !line_in;

  assign byte_ready = tx_mode && !coll_evt &&
                      (((st_q == ST_GUARD) && g_done) ||
                       (st_q == ST_IDLE) ||
                       ((st_q == ST_FRAME) && f_last));
  assign accept     = byte_valid && byte_ready;
  assign collision  = coll_q;

  hdx_guard_timer #(.CNT_W(GCNT_W)) u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (turn_evt),
    .load_val (g_val),
    .run      (g_run),
    .done     (g_done)
  );

  hdx_frame_shift #(.DATA_W(DATA_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_data (byte_data),
    .advance   (f_adv),
    .bit_out   (f_bit),
    .last_bit  (f_last)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RX:    if (tx_mode) st_d = ST_GUARD;
      ST_GUARD: begin
        if (coll_evt)      st_d = ST_LOCK;
        else if (!tx_mode) st_d = ST_RX;
        else if (g_done)   st_d = accept ? ST_FRAME : ST_IDLE;
      end
      ST_IDLE: begin
        if (coll_evt)      st_d = ST_LOCK;
        else if (!tx_mode) st_d = ST_RX;
        else if (accept)   st_d = ST_FRAME;
      end
      ST_FRAME: begin
        if (coll_evt)      st_d = ST_LOCK;
        else if (f_last) begin
          if (accept)       st_d = ST_FRAME;
          else if (tx_mode) st_d = ST_IDLE;
          else              st_d = ST_RX;
        end
      end
      ST_LOCK:  if (!tx_mode) st_d = ST_RX;
      default:  st_d = ST_RX;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_RX;
      coll_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (coll_evt)      coll_q <= 1'b1;
      else if (turn_evt) coll_q <= 1'b0;
    end
  end

  // Assertions
  assert_rx_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_mode && !drv_en) |=> (!drv_en && !byte_ready));

  assert_no_early_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_GUARD) && !g_done) |-> !byte_ready);

  assert_ready_needs_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready |-> tx_mode);

  assert_frame_then_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_FRAME) && f_last && !tx_mode && !coll_evt) |=> !drv_en);

  assert_coll_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    coll_evt |=> (!drv_en && collision));

  assert_coll_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (collision && !turn_evt) |=> collision);

  assert_turn_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    turn_evt |=> (!collision && drv_en && drv_data));

endmodule

// File: tb/hdx_tx_bench.sv
module hdx_tx_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tx_mode;
  logic [2:0] guard_sel;
  logic [7:0] byte_data;
  logic       byte_valid;
  logic       byte_ready;
  logic       line_in;
  logic       drv_en;
  logic       drv_data;
  logic       collision;
  logic       force_low;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  // Shared line: pulled high, follows our driver, overridable low by the far end.
  assign line_in = force_low ? 1'b0 : (drv_en ? drv_data : 1'b1);

  hdx_tx u_hdx_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_mode    (tx_mode),
    .guard_sel  (guard_sel),
    .byte_data  (byte_data),
    .byte_valid (byte_valid),
    .byte_ready (byte_ready),
    .line_in    (line_in),
    .drv_en     (drv_en),
    .drv_data   (drv_data),
    .collision  (collision)
  );

  function automatic int exp_extra(input logic [2:0] c);
    if (c < 3'd2) return 128;
    return 128 >> (c - 1);
  endfunction

  function automatic logic exp_bit(input logic [7:0] d, input int i);
    logic p;
    p = 1'b0;
    for (int k = 0; k < 8; k++) p = p ^ d[k];
    if (i == 0) return 1'b0;
    if (i <= 8) return d[i-1];
    if (i == 9) return p;
    return 1'b1;
  endfunction

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Turnaround from the released state up to the first start bit.
  task automatic turn_to_start(input logic [2:0] c, input logic [7:0] d, input bit scramble);
    int n;
    tx_mode = 1'b0; byte_valid = 1'b0;
    tick; tick;
    guard_sel = c; byte_data = d; byte_valid = 1'b1; tx_mode = 1'b1;
    tick;
    if (scramble) guard_sel = 3'($urandom);
    n = 0;
    while (drv_en && drv_data && n < 400) begin
      n++;
      tick;
    end
    chk(n == 2 + exp_extra(c), "R2 R3 idle bits before start", n, 2 + exp_extra(c));
  endtask

  // Called in the start-bit cycle; leaves the bench in the second stop bit cycle.
  task automatic check_frame(input logic [7:0] d, input bit glitch, input int drop_at,
                             input bit nv, input logic [7:0] nd);
    byte_valid = 1'b0;
    chk(drv_en && !drv_data, "R4 start bit", int'(drv_data), 0);
    for (int i = 1; i < 12; i++) begin
      tick;
      chk(drv_en && (drv_data == exp_bit(d, i)), "R4 frame bit", int'(drv_data), int'(exp_bit(d, i)));
      if (i == drop_at) tx_mode = 1'b0;
      if (glitch && i == 5) begin
        chk(!byte_ready, "R10 ready low mid-frame", int'(byte_ready), 0);
        byte_valid = 1'b1; byte_data = ~d;
      end
      if (glitch && i == 6) byte_valid = 1'b0;
      if (i == 11) begin
        chk(byte_ready == tx_mode, "R5 ready at second stop", int'(byte_ready), int'(tx_mode));
        if (nv) begin byte_valid = 1'b1; byte_data = nd; end
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d2;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; tx_mode = 1'b0; guard_sel = 3'd0; byte_data = 8'h00;
    byte_valid = 1'b0; force_low = 1'b0;
    tick; tick;
    chk(!drv_en && !collision && !byte_ready, "R1 reset state", int'(drv_en), 0);
    #2 rst_n = 1'b1;
    tick;
    tx_mode = 1'b1;
    chk(!drv_en && !byte_ready && !collision, "R1 released with tx_mode low", int'(drv_en), 0);
    tx_mode = 1'b0;

    // Every guard code, byte already waiting
    for (int c = 0; c < 8; c++) begin
      d = 8'($urandom);
      turn_to_start(3'(c), d, 1'b0);
      check_frame(d, 1'b0, -1, 1'b0, 8'h00);
      tick;
      chk(drv_en && drv_data && byte_ready, "R5 idle high after frame", int'(drv_data), 1);
    end

    // Back-to-back frames, no gap
    turn_to_start(3'd7, 8'hA5, 1'b0);
    check_frame(8'hA5, 1'b0, -1, 1'b1, 8'h3C);
    tick;
    check_frame(8'h3C, 1'b0, -1, 1'b0, 8'h00);

    // Offer while not ready is ignored
    tick;
    check_frame_glitch: begin
      byte_valid = 1'b1; byte_data = 8'h81;
      tick;
      check_frame(8'h81, 1'b1, -1, 1'b0, 8'h00);
      for (int k = 0; k < 3; k++) begin
        tick;
        chk(drv_en && drv_data, "R10 no frame from withdrawn offer", int'(drv_data), 1);
      end
    end

    // Release from transmit idle
    tx_mode = 1'b0;
    tick;
    chk(!drv_en, "R6 release from idle", int'(drv_en), 0);

    // Release during guard time
    guard_sel = 3'd0; byte_valid = 1'b0; tx_mode = 1'b1;
    tick; tick; tick;
    chk(drv_en && !byte_ready, "R2 guard still running", int'(byte_ready), 0);
    tx_mode = 1'b0;
    tick;
    chk(!drv_en, "R6 release from guard", int'(drv_en), 0);

    // Release request mid-frame: frame completes
    turn_to_start(3'd6, 8'h5A, 1'b0);
    check_frame(8'h5A, 1'b0, 4, 1'b0, 8'h00);
    tick;
    chk(!drv_en, "R6 release after frame", int'(drv_en), 0);

    // Collision on a driven one; low while driving zero ignored
    turn_to_start(3'd7, 8'b0000_0010, 1'b0);
    byte_valid = 1'b0;
    tick;
    force_low = 1'b1;
    tick;
    chk(drv_en && !collision, "R7 low on driven zero ignored", int'(collision), 0);
    tick;
    force_low = 1'b0;
    chk(!drv_en && collision, "R7 collision releases line", int'(drv_en), 0);
    for (int k = 0; k < 5; k++) begin
      tick;
      chk(collision && !drv_en, "R9 collision sticky", int'(collision), 1);
    end
    tx_mode = 1'b0;
    tick;
    chk(collision && !drv_en, "R9 sticky through release", int'(collision), 1);
    guard_sel = 3'd7; tx_mode = 1'b1;
    tick;
    chk(!collision && drv_en && drv_data, "R9 cleared at turnaround", int'(collision), 0);

    // Break held across an all-zero frame: caught on first stop bit
    turn_to_start(3'd7, 8'h00, 1'b0);
    byte_valid = 1'b0;
    force_low = 1'b1;
    for (int i = 1; i < 11; i++) begin
      tick;
      chk(drv_en && !collision, "R8 no collision before stop", int'(collision), 0);
    end
    tick;
    force_low = 1'b0;
    chk(collision && !drv_en, "R8 break seen as collision", int'(collision), 1);

    // Random frames, random chains, guard code changed after turnaround
    for (int r = 0; r < 20; r++) begin
      int chain;
      d = 8'($urandom);
      chain = int'($urandom % 3);
      turn_to_start(3'($urandom), d, 1'b1);
      for (int j = 0; j <= chain; j++) begin
        d2 = 8'($urandom);
        check_frame(d, 1'b0, -1, (j < chain), d2);
        tick;
        d = d2;
      end
      chk(drv_en && drv_data, "R5 idle after random chain", int'(drv_data), 1);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule